// File: doc/BRIEF.md
# Block Node-Budget Scheduler

This block enforces a run-time limit on a depth-first tree-search detector that works through a block of symbol vectors. The limit is an average number of visited nodes per vector, taken over the whole block. Software or a higher-level controller starts a block and supplies the average budget. The detector then starts each vector with its 1-based index. Before the search of that vector begins, the scheduler works out how many nodes the vector may visit.

The allowance follows a greedy, maximum-first policy. A vector may spend everything left in the block's pool except a reserve of one tree depth per later vector. That reserve is enough for a single first descent on each vector still to come. The detector pulses a strobe for every node it visits, counting leaves and not the root. When the strobe that uses up the allowance arrives, the scheduler raises a terminate output in that same cycle. The detector then reports its best hypotheses so far and signals that the vector is done, and that vector's node count is charged to the block pool.

Top module: `node_budget_top`

## Requirements
- R1: After reset, `terminate` is low and `allowance` is zero.
- R2: One cycle after a `vecStart` pulse with index k (1 to NUM_VEC), `allowance` equals NUM_VEC*Davg minus the nodes charged so far in the block minus (NUM_VEC-k)*DEPTH.
- R3: A `blockStart` pulse clears the charged-node pool. Each `vecDone` adds the vector's accepted node count to the pool.
- R4: `terminate` rises combinationally in the cycle of the `nodeVisit` strobe that brings the vector's count up to its allowance. It stays low on every earlier strobe.
- R5: Once raised, `terminate` stays high until the `vecDone` cycle, including that cycle, and is low in the cycle after.
- R6: Strobes that arrive after `terminate` has been raised are not charged to the pool.
- R7: When the formula of R2 gives less than DEPTH, or a negative value, `allowance` is DEPTH.
- R8: With Davg equal to DEPTH and the vectors taken in order, every vector that spends its full allowance receives exactly DEPTH nodes.
- R9: `nodeVisit` strobes while no vector is active are not charged.
- R10: Davg is sampled only on `blockStart`. Changing `avgBudget` later in the block has no effect on the allowances.
- R11: A `nodeVisit` strobe in the same cycle as `vecDone` is charged to the pool if `terminate` was not yet raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| blockStart | input | 1 | Pulse: start a new block, clear the pool, sample `avgBudget` |
| avgBudget | input | AVG_W | Average node budget per vector (Davg) |
| vecStart | input | 1 | Pulse: start the vector given on `vecIdx` |
| vecIdx | input | IDX_W | 1-based vector index k within the block |
| nodeVisit | input | 1 | One pulse per visited node |
| vecDone | input | 1 | Pulse: the current vector has finished |
| terminate | output | 1 | Stop searching the current vector |
| allowance | output | CNT_W | Node allowance of the current vector |

## Verification
The assertions assume the following about the inputs:
- `vecIdx` lies between 1 and NUM_VEC when `vecStart` pulses.
- `vecStart` does not arrive while a vector is still active.
- `blockStart` and `vecStart` never fall in the same cycle as `vecDone`.

The stimulus keeps to these rules. Every vector is started and closed in its own cycles, and each new block begins only after the previous vector's done pulse. Indices are chosen inside the legal range, including skips and out-of-order starts, so that the clamp is reached without ever wrapping the reserve term.

// File: rtl/node_budget_pkg.sv
package node_budget_pkg;

  // Strobes from the control to the datapath, valid for one cycle each
  typedef struct packed {
    logic clearAcc;   // new block: clear pool, sample budget
    logic loadAllow;  // new vector: register its allowance
    logic clearCnt;   // new vector: clear per-vector counter
    logic bumpCnt;    // accepted visit strobe
    logic commit;     // vector done: charge count to pool
  } budgetStrobes_t;

endpackage

// File: rtl/node_budget_ctrl.sv
module node_budget_ctrl
  import node_budget_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic           blockStart,
  input  logic           vecStart,
  input  logic           nodeVisit,
  input  logic           vecDone,
  input  logic           hitLimit,
  output budgetStrobes_t strb,
  output logic           terminate
);

  logic active;
  logic termHeld;
  logic accepted;

  always_comb begin
    accepted       = active & nodeVisit & ~termHeld;
    strb.clearAcc  = blockStart;
    strb.loadAllow = vecStart;
    strb.clearCnt  = vecStart;
    strb.bumpCnt   = accepted & ~vecStart;
    strb.commit    = active & vecDone & ~vecStart;
    terminate      = active & (termHeld | (nodeVisit & hitLimit));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active   <= 1'b0;
      termHeld <= 1'b0;
    end else if (vecStart) begin
      active   <= 1'b1;
      termHeld <= 1'b0;
    end else if (blockStart || vecDone) begin
      active   <= 1'b0;
      termHeld <= 1'b0;
    end else if (accepted && hitLimit) begin
      termHeld <= 1'b1;
    end
  end

  // R4: terminate is only ever raised for an active vector
  assert_term_needs_vector_R4: assert property (@(posedge clk) disable iff (!rstN)
    terminate |-> active);

  // R5: terminate holds until the vector is closed
  assert_term_holds_R5: assert property (@(posedge clk) disable iff (!rstN)
    (terminate && !vecDone && !vecStart && !blockStart) |=> terminate);

  // R5: terminate drops after vecDone
  assert_term_clears_R5: assert property (@(posedge clk) disable iff (!rstN)
    (vecDone && !vecStart) |=> !terminate);

endmodule

// File: rtl/node_budget_dp.sv
module node_budget_dp
  import node_budget_pkg::*;
#(
  parameter int NUM_VEC = 64,
  parameter int DEPTH   = 4,
  parameter int AVG_W   = 8,
  parameter int IDX_W   = 7,
  parameter int CNT_W   = 14
) (
  input  logic             clk,
  input  logic             rstN,
  input  budgetStrobes_t   strb,
  input  logic [AVG_W-1:0] avgBudget,
  input  logic [IDX_W-1:0] vecIdx,
  output logic             hitLimit,
  output logic [CNT_W-1:0] allowance
);

  localparam int ACC_W = CNT_W + 1;
  localparam int SUM_W = ACC_W + 1;

  logic [AVG_W-1:0] davgQ;
  logic [ACC_W-1:0] acc;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] allowQ;

  logic [AVG_W-1:0] davgEff;
  logic [ACC_W-1:0] accEff;
  logic [SUM_W-1:0] totalNodes, reserveNodes, usedNodes, floorNodes, allowNext;
  logic [CNT_W:0]   cntPlusOne;

  always_comb begin
    davgEff      = strb.clearAcc ? avgBudget : davgQ;
    accEff       = strb.clearAcc ? '0 : acc;
    totalNodes   = SUM_W'(NUM_VEC) * SUM_W'(davgEff);
    reserveNodes = (SUM_W'(NUM_VEC) - SUM_W'(vecIdx)) * SUM_W'(DEPTH);
    usedNodes    = SUM_W'(accEff) + reserveNodes;
    floorNodes   = usedNodes + SUM_W'(DEPTH);
    allowNext    = (totalNodes >= floorNodes) ? (totalNodes - usedNodes)
                                              : SUM_W'(DEPTH);
    cntPlusOne   = {1'b0, cnt} + (CNT_W+1)'(1);
    hitLimit     = cntPlusOne >= {1'b0, allowQ};
    allowance    = allowQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      davgQ  <= '0;
      acc    <= '0;
      cnt    <= '0;
      allowQ <= '0;
    end else begin
      if (strb.clearAcc) begin
        davgQ <= avgBudget;
        acc   <= '0;
      end else if (strb.commit) begin
        acc <= acc + ACC_W'(cnt) + ACC_W'(strb.bumpCnt);
      end
      if (strb.loadAllow) allowQ <= CNT_W'(allowNext);
      if (strb.clearCnt)     cnt <= '0;
      else if (strb.bumpCnt) cnt <= cnt + CNT_W'(1);
    end
  end

  // R7: a freshly loaded allowance never falls below one tree depth
  assert_allow_floor_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadAllow |=> (allowQ >= CNT_W'(DEPTH)));

  // R6: accepted visits never exceed the allowance
  assert_count_within_allow_R6: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= allowQ);

  // R3: the pool only grows within a block
  assert_pool_monotonic_R3: assert property (@(posedge clk) disable iff (!rstN)
    !strb.clearAcc |=> (acc >= $past(acc)));

  // R10: the sampled budget only moves on a block start
  assert_budget_sampled_R10: assert property (@(posedge clk) disable iff (!rstN)
    !strb.clearAcc |=> $stable(davgQ));

endmodule

// File: rtl/node_budget_top.sv
module node_budget_top
  import node_budget_pkg::*;
#(
  parameter int NUM_VEC = 64,
  parameter int DEPTH   = 4,
  parameter int AVG_W   = 8,
  localparam int IDX_W  = $clog2(NUM_VEC + 1),
  localparam int CNT_W  = $clog2(NUM_VEC * ((1 << AVG_W) - 1) + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             blockStart,
  input  logic [AVG_W-1:0] avgBudget,
  input  logic             vecStart,
  input  logic [IDX_W-1:0] vecIdx,
  input  logic             nodeVisit,
  input  logic             vecDone,
  output logic             terminate,
  output logic [CNT_W-1:0] allowance
);

  budgetStrobes_t strb;
  logic           hitLimit;

  node_budget_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .blockStart (blockStart),
    .vecStart   (vecStart),
    .nodeVisit  (nodeVisit),
    .vecDone    (vecDone),
    .hitLimit   (hitLimit),
    .strb       (strb),
    .terminate  (terminate)
  );

  node_budget_dp #(
    .NUM_VEC (NUM_VEC),
    .DEPTH   (DEPTH),
    .AVG_W   (AVG_W),
    .IDX_W   (IDX_W),
    .CNT_W   (CNT_W)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .avgBudget (avgBudget),
    .vecIdx    (vecIdx),
    .hitLimit  (hitLimit),
    .allowance (allowance)
  );

endmodule

// File: tb/node_budget_tb.sv
module node_budget_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int N_ROWS     = 11;

  typedef struct packed {
    logic        newBlock;
    logic [7:0]  davg;
    logic [6:0]  k;
    logic [15:0] visits;
    logic [3:0]  extra;
    logic [15:0] expAllow;
  } row_t;

  // Block A: Davg=16, pool 1024. Block B/C: Davg=4, pool 256. DEPTH=4, N=64.
  localparam row_t TABLE [N_ROWS] = '{
    '{1'b1, 8'd16, 7'd1,  16'd10,  4'd0, 16'd772}, // R2 first vector
    '{1'b0, 8'd16, 7'd2,  16'd766, 4'd3, 16'd766}, // R2 R4 R6: extra strobes
    '{1'b0, 8'd16, 7'd3,  16'd4,   4'd0, 16'd4},   // R6: 776 charged, not 779
    '{1'b0, 8'd16, 7'd4,  16'd2,   4'd0, 16'd4},
    '{1'b0, 8'd16, 7'd5,  16'd6,   4'd0, 16'd6},
    '{1'b0, 8'd16, 7'd64, 16'd3,   4'd0, 16'd236}, // R2 last vector
    '{1'b1, 8'd4,  7'd1,  16'd4,   4'd1, 16'd4},   // R8
    '{1'b0, 8'd4,  7'd2,  16'd4,   4'd0, 16'd4},   // R8
    '{1'b1, 8'd4,  7'd10, 16'd40,  4'd0, 16'd40},  // R3 pool cleared
    '{1'b0, 8'd4,  7'd11, 16'd4,   4'd0, 16'd4},
    '{1'b0, 8'd4,  7'd3,  16'd1,   4'd0, 16'd4}    // R7 clamp of -32
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        blockStart = 1'b0;
  logic [7:0]  avgBudget = '0;
  logic        vecStart = 1'b0;
  logic [6:0]  vecIdx = '0;
  logic        nodeVisit = 1'b0;
  logic        vecDone = 1'b0;
  logic        terminate;
  logic [13:0] allowance;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  node_budget_top dut_i (
    .clk(clk), .rstN(rstN), .blockStart(blockStart), .avgBudget(avgBudget),
    .vecStart(vecStart), .vecIdx(vecIdx), .nodeVisit(nodeVisit),
    .vecDone(vecDone), .terminate(terminate), .allowance(allowance)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic startBlock(input logic [7:0] d);
    @(negedge clk); blockStart = 1'b1; avgBudget = d;
    @(negedge clk); blockStart = 1'b0;
  endtask

  task automatic startVec(input logic [6:0] k, input int expAllow, input string req);
    @(negedge clk); vecStart = 1'b1; vecIdx = k;
    @(negedge clk); vecStart = 1'b0;
    #1 check(allowance == 14'(expAllow), req, int'(allowance), expAllow);
  endtask

  task automatic runVec(input int visits, input int extra, input int expAllow);
    for (int i = 0; i < visits; i++) begin
      @(negedge clk); nodeVisit = 1'b1;
      #1 check(terminate == (i + 1 >= expAllow), "R4 terminate on strobe",
               int'(terminate), int'(i + 1 >= expAllow));
    end
    for (int i = 0; i < extra; i++) begin
      @(negedge clk); nodeVisit = 1'b1;
      #1 check(terminate == 1'b1, "R5 terminate held", int'(terminate), 1);
    end
    @(negedge clk); nodeVisit = 1'b0; vecDone = 1'b1;
    #1 check(terminate == (visits >= expAllow), "R5 terminate in done cycle",
             int'(terminate), int'(visits >= expAllow));
    @(negedge clk); vecDone = 1'b0;
    #1 check(terminate == 1'b0, "R5 terminate low after done", int'(terminate), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 check(terminate == 1'b0, "R1 reset terminate", int'(terminate), 0);
    check(allowance == '0, "R1 reset allowance", int'(allowance), 0);
    @(negedge clk); rstN = 1'b1;

    for (int r = 0; r < N_ROWS; r++) begin
      if (TABLE[r].newBlock) startBlock(TABLE[r].davg);
      startVec(TABLE[r].k, int'(TABLE[r].expAllow), "R2 R6 R7 R8 allowance");
      runVec(int'(TABLE[r].visits), int'(TABLE[r].extra), int'(TABLE[r].expAllow));
    end
    // pool now 45 in a 256 block

    // R9: idle strobes are not charged; R10: budget input change ignored
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); nodeVisit = 1'b1;
      #1 check(terminate == 1'b0, "R9 idle strobe", int'(terminate), 0);
    end
    @(negedge clk); nodeVisit = 1'b0; avgBudget = 8'd100;
    startVec(7'd64, 211, "R9 R10 allowance after idle strobes");

    // R11: strobe coinciding with vecDone is charged
    for (int i = 0; i < 2; i++) begin
      @(negedge clk); nodeVisit = 1'b1;
    end
    @(negedge clk); nodeVisit = 1'b1; vecDone = 1'b1;
    @(negedge clk); nodeVisit = 1'b0; vecDone = 1'b0;
    startVec(7'd64, 208, "R11 done-cycle strobe charged");
    runVec(0, 0, 208);

    // R3: new block clears pool; R10: new budget taken at block start
    startBlock(8'd4);
    startVec(7'd64, 256, "R3 pool cleared at block start");
    runVec(0, 0, 256);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule